// File: doc/BRIEF.md
# Multiplexed Local Bus Sequencer

This block is a master for a local bus on which address and data share one set of sixteen lines. An internal requester starts one transfer at a time: a read, a write or a read-modify-write. Each transfer carries a start address, a byte count from 1 to 8, up to eight write bytes and a per-byte merge mask. The block splits the transfer into beats. Each beat has one address cycle, with the address-latch strobe high and the address driven, followed by one data cycle. The requester also picks the port width, 8 or 16 bits, for each transfer.

The bus numbers its lanes big-endian, so lane 0 is the most significant bit of `bus_ad_o`/`bus_ad_i`. Lanes 0 to 7 are bits [15:8] and lanes 8 to 15 are bits [7:0]. Operand byte i sits at bits [8i+7:8i] of the request data and of the returned read data.

Before an address cycle, the block inserts exactly one idle turnaround cycle if the master was not driving the lines in the cycle before. It inserts none if the master was driving them.

Top module: `mlb_sequencer`

## Requirements
- R1: On a 16-bit port each full beat moves two operand bytes. The lower-numbered (even) byte travels on bits [15:8] and the next byte on bits [7:0]. The beat address then advances by 2.
- R2: On an 8-bit port each beat moves one byte on bits [15:8]. In a write data cycle, bits [7:0] are driven as zero. The beat address advances by 1.
- R3: On a 16-bit port with an odd byte count, the final beat moves a single byte on bits [15:8]. Bits [7:0] are zero in a write data cycle and are ignored in a read data cycle.
- R4: Each beat is one address cycle followed by one data cycle. In the address cycle `bus_ale`=1, `bus_oe`=1 and `bus_ad_o` carries the beat address. In the data cycle `bus_ale`=0. `bus_oe` is high only in address cycles and write data cycles. `bus_wr` is high in both cycles of a write beat.
- R5: When `bus_oe` was low in the previous cycle, exactly one cycle with `bus_ale`=0 and `bus_oe`=0 comes before the address cycle. This also holds for the first beat after idle and after every read data cycle.
- R6: After a write data cycle, the next address cycle of the same transfer follows at once, with no turnaround.
- R7: `req_op` encodes 0 = read, 1 = write, 2 = read-modify-write (3 acts as read). When `done` is high, `rdata` holds the bytes read, with byte i at bits [8i+7:8i]. Bytes at or above the count are zero, and so is all of `rdata` after a plain write.
- R8: A read-modify-write reads every byte first. It then runs a write pass from the same start address, with its own fresh address cycles and one turnaround before them. Write byte i equals `req_wdata` byte i where `req_mask[i]`=1, and the read byte otherwise. `rdata` returns the unmerged read bytes.
- R9: `busy` is high from the cycle after a start until the final data cycle. `done` is a one-cycle pulse in the cycle after the final data cycle. A `req_start` while `busy` is high is ignored.
- R10: During and right after reset, `busy`, `done`, `bus_ale`, `bus_oe` and `bus_wr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Start pulse, taken only when idle |
| req_op | input | 2 | Operation code (0 read, 1 write, 2 read-modify-write) |
| req_wide | input | 1 | 1 selects the 16-bit port, 0 the 8-bit port |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | CNT_W | Byte count, 1 to MAX_BYTES |
| req_wdata | input | 8*MAX_BYTES | Write bytes, byte i at bits [8i+7:8i] |
| req_mask | input | MAX_BYTES | Merge mask for read-modify-write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8*MAX_BYTES | Packed read bytes |
| bus_ale | output | 1 | Address-latch strobe |
| bus_oe | output | 1 | Master drives the shared lines |
| bus_wr | output | 1 | Current beat is a write |
| bus_ad_o | output | 16 | Value driven on the shared lines |
| bus_ad_i | input | 16 | Value sampled from the shared lines |

## Verification
The hardest case to reach from the ports is the handover inside a read-modify-write. The last read data cycle releases the lines, the mask merge and the first write address fall in the following cycles, and the turnaround must appear once between them. The stimulus reaches it with read-modify-writes on both port widths and with mixed masks. A device model answers every read with known bytes and puts a junk pattern on the unused low lanes. The scoreboard predicts every bus cycle of the transfer, including each turnaround, and the merged write bytes. A start pulse sent in the middle of a long write shows whether it disturbs the predicted trace.

// File: rtl/mlb_pkg.sv
package mlb_pkg;

    localparam int LANE_W = 16;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_RMW   = 2'b10,
        OP_RSVD  = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_TURN,
        ST_ADDR,
        ST_DATA
    } st_e;

    typedef struct packed {
        logic ale;
        logic oe;
        logic wr;
    } bus_ctl_t;

    // bytes carried by one beat, given port width and bytes still to move
    function automatic logic beat_is_pair(logic wide, int unsigned left);
        return wide && (left >= 2);
    endfunction

endpackage

// File: rtl/mlb_beat_ctrl.sv
module mlb_beat_ctrl
    import mlb_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int MAX_BYTES = 8,
    parameter int CNT_W     = $clog2(MAX_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  op_e               op,
    input  logic              wide,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  len,
    output bus_ctl_t          ctl,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] beat_addr,
    output logic [CNT_W-1:0]  idx,
    output logic              pair,
    output logic              in_addr,
    output logic              in_wdata,
    output logic              load_en,
    output logic              cap_en,
    output logic              merge_en
);

    st_e               st_q;
    logic              pass_wr_q;
    op_e               op_q;
    logic              wide_q;
    logic [CNT_W-1:0]  len_q;
    logic [CNT_W-1:0]  idx_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] baddr_q;
    logic              done_q;

    logic [CNT_W-1:0]  left;
    logic [CNT_W-1:0]  step;
    logic [CNT_W-1:0]  idx_nx;
    logic              last_beat;
    logic              oe_now;
    st_e               beat_entry;

    assign left      = len_q - idx_q;
    assign pair      = beat_is_pair(wide_q, int'(left));
    assign step      = pair ? CNT_W'(2) : CNT_W'(1);
    assign idx_nx    = idx_q + step;
    assign last_beat = (idx_nx >= len_q);

    // the master drives the lines in address cycles and write data cycles
    assign oe_now     = (st_q == ST_ADDR) || (st_q == ST_DATA && pass_wr_q);
    // a beat starts straight away only if the lines are driven right now
    assign beat_entry = oe_now ? ST_ADDR : ST_TURN;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            pass_wr_q <= 1'b0;
            op_q      <= OP_READ;
            wide_q    <= 1'b0;
            len_q     <= '0;
            idx_q     <= '0;
            base_q    <= '0;
            baddr_q   <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        op_q      <= op;
                        wide_q    <= wide;
                        len_q     <= len;
                        idx_q     <= '0;
                        base_q    <= addr;
                        baddr_q   <= addr;
                        pass_wr_q <= (op == OP_WRITE);
                        st_q      <= beat_entry;
                    end
                end
                ST_TURN: st_q <= ST_ADDR;
                ST_ADDR: st_q <= ST_DATA;
                ST_DATA: begin
                    if (!last_beat) begin
                        idx_q   <= idx_nx;
                        baddr_q <= baddr_q + ADDR_W'(step);
                        st_q    <= beat_entry;
                    end else if (!pass_wr_q && op_q == OP_RMW) begin
                        pass_wr_q <= 1'b1;
                        idx_q     <= '0;
                        baddr_q   <= base_q;
                        st_q      <= beat_entry;
                    end else begin
                        done_q <= 1'b1;
                        st_q   <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign ctl.ale   = (st_q == ST_ADDR);
    assign ctl.oe    = oe_now;
    assign ctl.wr    = pass_wr_q && (st_q == ST_ADDR || st_q == ST_DATA);
    assign busy      = (st_q != ST_IDLE);
    assign done      = done_q;
    assign beat_addr = baddr_q;
    assign idx       = idx_q;
    assign in_addr   = (st_q == ST_ADDR);
    assign in_wdata  = (st_q == ST_DATA) && pass_wr_q;
    assign load_en   = (st_q == ST_IDLE) && start;
    assign cap_en    = (st_q == ST_DATA) && !pass_wr_q;
    assign merge_en  = cap_en && last_beat && (op_q == OP_RMW);

    // R5: a turnaround cycle is always followed by an address cycle
    assert_turn_then_addr_R5: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_TURN) |=> (st_q == ST_ADDR));

    // R5: an address cycle follows either a driven cycle or a turnaround
    assert_addr_after_drive_R5: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_ADDR) |-> ($past(ctl.oe) || $past(st_q == ST_TURN)));

    // R6: a write data cycle is never followed by a turnaround
    assert_no_turn_after_write_R6: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_DATA && pass_wr_q) |=> (st_q != ST_TURN));

    // R9: byte index stays inside the count during data cycles
    assert_idx_bound_R9: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_DATA && len_q != '0) |-> (idx_q < len_q));

    // R9: completion is a single-cycle pulse
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

endmodule

// File: rtl/mlb_lane_map.sv
module mlb_lane_map
    import mlb_pkg::*;
#(
    parameter int MAX_BYTES = 8,
    parameter int CNT_W     = $clog2(MAX_BYTES + 1)
) (
    input  logic [8*MAX_BYTES-1:0] wbuf,
    input  logic [8*MAX_BYTES-1:0] rbuf,
    input  logic [CNT_W-1:0]       idx,
    input  logic                   pair,
    input  logic [LANE_W-1:0]      lanes_in,
    output logic [LANE_W-1:0]      lanes_out,
    output logic [8*MAX_BYTES-1:0] rbuf_cap
);

    logic [CNT_W-1:0] idx_odd;
    logic [7:0]       hi_byte;
    logic [7:0]       lo_byte;

    assign idx_odd = idx + CNT_W'(1);

    // pick the outgoing bytes: even one on lanes 0..7, odd one on lanes 8..15
    always_comb begin
        hi_byte = 8'h00;
        lo_byte = 8'h00;
        for (int i = 0; i < MAX_BYTES; i++) begin
            if (CNT_W'(i) == idx) hi_byte = wbuf[8*i +: 8];
            if (pair && CNT_W'(i) == idx_odd) lo_byte = wbuf[8*i +: 8];
        end
    end

    assign lanes_out = {hi_byte, lo_byte};

    // scatter the incoming lanes back into operand order
    for (genvar g = 0; g < MAX_BYTES; g++) begin : g_cap
        assign rbuf_cap[8*g +: 8] =
            (CNT_W'(g) == idx)             ? lanes_in[15:8] :
            (pair && CNT_W'(g) == idx_odd) ? lanes_in[7:0]  :
                                             rbuf[8*g +: 8];
    end

endmodule

// File: rtl/mlb_rmw_merge.sv
module mlb_rmw_merge #(
    parameter int MAX_BYTES = 8
) (
    input  logic [8*MAX_BYTES-1:0] new_bytes,
    input  logic [8*MAX_BYTES-1:0] old_bytes,
    input  logic [MAX_BYTES-1:0]   mask,
    output logic [8*MAX_BYTES-1:0] merged
);

    for (genvar g = 0; g < MAX_BYTES; g++) begin : g_byte
        assign merged[8*g +: 8] = mask[g] ? new_bytes[8*g +: 8] : old_bytes[8*g +: 8];
    end

endmodule

// File: rtl/mlb_sequencer.sv
module mlb_sequencer
    import mlb_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int MAX_BYTES = 8,
    parameter int CNT_W     = $clog2(MAX_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_start,
    input  logic [1:0]             req_op,
    input  logic                   req_wide,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [CNT_W-1:0]       req_len,
    input  logic [8*MAX_BYTES-1:0] req_wdata,
    input  logic [MAX_BYTES-1:0]   req_mask,
    output logic                   busy,
    output logic                   done,
    output logic [8*MAX_BYTES-1:0] rdata,
    output logic                   bus_ale,
    output logic                   bus_oe,
    output logic                   bus_wr,
    output logic [LANE_W-1:0]      bus_ad_o,
    input  logic [LANE_W-1:0]      bus_ad_i
);

    localparam int DATA_W = 8 * MAX_BYTES;

    bus_ctl_t          ctl;
    logic [ADDR_W-1:0] beat_addr;
    logic [CNT_W-1:0]  idx;
    logic              pair;
    logic              in_addr;
    logic              in_wdata;
    logic              load_en;
    logic              cap_en;
    logic              merge_en;

    logic [DATA_W-1:0]    wbuf_q;
    logic [DATA_W-1:0]    rbuf_q;
    logic [MAX_BYTES-1:0] mask_q;
    logic [DATA_W-1:0]    rbuf_cap;
    logic [DATA_W-1:0]    merged;
    logic [LANE_W-1:0]    wr_lanes;

    mlb_beat_ctrl #(
        .ADDR_W(ADDR_W), .MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (req_start),
        .op       (op_e'(req_op)),
        .wide     (req_wide),
        .addr     (req_addr),
        .len      (req_len),
        .ctl      (ctl),
        .busy     (busy),
        .done     (done),
        .beat_addr(beat_addr),
        .idx      (idx),
        .pair     (pair),
        .in_addr  (in_addr),
        .in_wdata (in_wdata),
        .load_en  (load_en),
        .cap_en   (cap_en),
        .merge_en (merge_en)
    );

    mlb_lane_map #(
        .MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)
    ) u_lanes (
        .wbuf     (wbuf_q),
        .rbuf     (rbuf_q),
        .idx      (idx),
        .pair     (pair),
        .lanes_in (bus_ad_i),
        .lanes_out(wr_lanes),
        .rbuf_cap (rbuf_cap)
    );

    mlb_rmw_merge #(
        .MAX_BYTES(MAX_BYTES)
    ) u_merge (
        .new_bytes(wbuf_q),
        .old_bytes(rbuf_cap),
        .mask     (mask_q),
        .merged   (merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wbuf_q <= '0;
            rbuf_q <= '0;
            mask_q <= '0;
        end else if (load_en) begin
            wbuf_q <= req_wdata;
            rbuf_q <= '0;
            mask_q <= req_mask;
        end else begin
            if (cap_en)   rbuf_q <= rbuf_cap;
            if (merge_en) wbuf_q <= merged;
        end
    end

    always_comb begin
        if (in_addr)       bus_ad_o = LANE_W'(beat_addr);
        else if (in_wdata) bus_ad_o = wr_lanes;
        else               bus_ad_o = '0;
    end

    assign bus_ale = ctl.ale;
    assign bus_oe  = ctl.oe;
    assign bus_wr  = ctl.wr;
    assign rdata   = rbuf_q;

    // R4: the address strobe only appears while the master drives the lines
    assert_ale_driven_R4: assert property (@(posedge clk) disable iff (rst)
        bus_ale |-> bus_oe);

    // R4: every address cycle is followed by a data cycle without strobe
    assert_addr_then_data_R4: assert property (@(posedge clk) disable iff (rst)
        bus_ale |=> !bus_ale);

    // R2: single-byte write beats keep the low lanes at zero
    assert_low_lanes_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (in_wdata && !pair) |-> (bus_ad_o[7:0] == 8'h00));

    // R9: nothing is driven while idle
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!bus_oe && !bus_ale && !bus_wr));

endmodule

// File: tb/mlb_sequencer_tb_top.sv
`timescale 1ns/1ps
module mlb_sequencer_tb_top;

    localparam int ADDR_W    = 16;
    localparam int MAX_BYTES = 8;
    localparam int CNT_W     = $clog2(MAX_BYTES + 1);

    typedef struct {
        logic  ale;
        logic  oe;
        logic  wr;
        logic [15:0] ad;
        string tag;
    } rec_t;

    typedef struct {
        logic [63:0] data;
        string       tag;
    } rd_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_start = 1'b0;
    logic [1:0]        req_op = 2'd0;
    logic              req_wide = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [CNT_W-1:0]  req_len = '0;
    logic [63:0]       req_wdata = '0;
    logic [7:0]        req_mask = '0;
    logic              busy, done, bus_ale, bus_oe, bus_wr;
    logic [63:0]       rdata;
    logic [15:0]       bus_ad_o, bus_ad_i;

    int total = 0;
    int bad = 0;
    logic finished = 1'b0;

    rec_t exp_q[$];
    rd_t  rd_q[$];

    logic [7:0] mem [0:255];
    logic [7:0] lat_a = 8'h00;
    logic       dev_wide = 1'b0;
    logic       prev_done = 1'b0;

    always #2 clk = ~clk;

    mlb_sequencer #(.ADDR_W(ADDR_W), .MAX_BYTES(MAX_BYTES)) dut_i (
        .clk(clk), .rst(rst), .req_start(req_start), .req_op(req_op),
        .req_wide(req_wide), .req_addr(req_addr), .req_len(req_len),
        .req_wdata(req_wdata), .req_mask(req_mask), .busy(busy), .done(done),
        .rdata(rdata), .bus_ale(bus_ale), .bus_oe(bus_oe), .bus_wr(bus_wr),
        .bus_ad_o(bus_ad_o), .bus_ad_i(bus_ad_i)
    );

    // device model: latches the address, answers with memory bytes, junk on unused lanes
    always @(posedge clk) if (bus_ale) lat_a <= bus_ad_o[7:0];
    assign bus_ad_i = {mem[lat_a], dev_wide ? mem[lat_a + 8'd1] : 8'hA5};

    task automatic check(input logic ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (busy) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected busy cycle", 64'(bus_ad_o), 64'h0);
                end else begin
                    rec_t e;
                    logic [18:0] a, x;
                    e = exp_q.pop_front();
                    a = {bus_ale, bus_oe, bus_wr, e.oe ? bus_ad_o : 16'h0};
                    x = {e.ale, e.oe, e.wr, e.oe ? e.ad : 16'h0};
                    check(a == x, e.tag, "bus cycle {ale,oe,wr,ad}", 64'(a), 64'(x));
                end
            end
            if (done) begin
                if (rd_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected done", rdata, 64'h0);
                end else begin
                    rd_t r;
                    r = rd_q.pop_front();
                    check(rdata == r.data, r.tag, "rdata", rdata, r.data);
                end
                if (prev_done) check(1'b0, "R9", "done longer than one cycle", 64'd1, 64'd0);
            end
            prev_done <= done;
        end
    end

    task automatic add_pass(input logic is_wr, input logic wide, input logic [15:0] addr,
                            input int len, input logic [7:0] b [8], inout logic prev_oe);
        int i = 0;
        logic [15:0] a = addr;
        while (i < len) begin
            rec_t r;
            int nb = (wide && (len - i) >= 2) ? 2 : 1;
            if (!prev_oe) begin
                r = '{1'b0, 1'b0, 1'b0, 16'h0, "R5"};
                exp_q.push_back(r);
            end
            r = '{1'b1, 1'b1, is_wr, a, (prev_oe ? "R6" : "R4")};
            exp_q.push_back(r);
            if (is_wr)
                r = '{1'b0, 1'b1, 1'b1, {b[i], (nb == 2) ? b[i+1] : 8'h00},
                      (nb == 2) ? "R1" : (wide ? "R3" : "R2")};
            else
                r = '{1'b0, 1'b0, 1'b0, 16'h0, "R4"};
            exp_q.push_back(r);
            prev_oe = is_wr;
            i += nb;
            a += 16'(nb);
        end
    endtask

    task automatic run_req(input logic [1:0] op, input logic wide, input logic [15:0] addr,
                           input int len, input logic [63:0] wdata, input logic [7:0] mask,
                           input logic poke, input string rtag);
        logic [7:0] rb [8];
        logic [7:0] wb [8];
        logic [63:0] rexp = '0;
        logic prev_oe = 1'b0;
        rd_t rr;
        for (int i = 0; i < 8; i++) begin
            rb[i] = (i < len) ? mem[8'(addr + 16'(i))] : 8'h00;
            if (op == 2'd1) wb[i] = wdata[8*i +: 8];
            else            wb[i] = mask[i] ? wdata[8*i +: 8] : rb[i];
            if (op != 2'd1) rexp[8*i +: 8] = rb[i];
        end
        if (op != 2'd1) add_pass(1'b0, wide, addr, len, rb, prev_oe);
        if (op == 2'd1 || op == 2'd2) add_pass(1'b1, wide, addr, len, wb, prev_oe);
        rr = '{rexp, rtag};
        rd_q.push_back(rr);
        dev_wide = wide;
        @(negedge clk);
        req_start = 1'b1; req_op = op; req_wide = wide; req_addr = addr;
        req_len = CNT_W'(len); req_wdata = wdata; req_mask = mask;
        @(negedge clk);
        req_start = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            req_start = 1'b1; req_op = 2'd0; req_wide = ~wide; req_addr = 16'h00F0; req_len = 4'd2;
            @(negedge clk);
            req_start = 1'b0;
        end
        while (rd_q.size() != 0) @(negedge clk);
        @(negedge clk);
        if (op == 2'd1 || op == 2'd2)
            for (int i = 0; i < len; i++) mem[8'(addr + 16'(i))] = wb[i];
        check(exp_q.size() == 0 && !busy, rtag, "trace fully consumed", 64'(exp_q.size()), 64'd0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        check({busy, done, bus_ale, bus_oe, bus_wr} == 5'b0, "R10", "outputs in reset",
              64'({busy, done, bus_ale, bus_oe, bus_wr}), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check({busy, done, bus_ale, bus_oe, bus_wr} == 5'b0, "R10", "outputs after reset",
              64'({busy, done, bus_ale, bus_oe, bus_wr}), 64'd0);

        run_req(2'd0, 1'b1, 16'h0010, 4, 64'h0, 8'h00, 1'b0, "R7");               // R1 R7 wide read
        run_req(2'd1, 1'b1, 16'h0020, 4, 64'h44332211, 8'h00, 1'b0, "R7");        // R1 R6 wide write
        run_req(2'd1, 1'b0, 16'h0031, 3, 64'hC0B0A0, 8'h00, 1'b0, "R7");          // R2 R6 narrow write
        run_req(2'd0, 1'b0, 16'h0040, 2, 64'h0, 8'h00, 1'b0, "R7");               // R2 narrow read, junk low lanes
        run_req(2'd0, 1'b1, 16'h0050, 3, 64'h0, 8'h00, 1'b0, "R3");               // R3 odd wide read
        run_req(2'd1, 1'b1, 16'h0060, 5, 64'h5544332211, 8'h00, 1'b0, "R3");      // R3 odd wide write
        run_req(2'd2, 1'b1, 16'h0020, 4, 64'hDDCCBBAA, 8'h05, 1'b0, "R8");        // R8 wide rmw
        run_req(2'd2, 1'b0, 16'h0070, 3, 64'h00EEFF11, 8'h06, 1'b0, "R8");        // R8 narrow rmw
        run_req(2'd1, 1'b1, 16'h0080, 8, 64'h8877665544332211, 8'h00, 1'b1, "R9"); // R9 start ignored
        run_req(2'd0, 1'b1, 16'h0080, 8, 64'h0, 8'h00, 1'b0, "R7");               // R7 full read
        run_req(2'd0, 1'b0, 16'h0033, 1, 64'h0, 8'h00, 1'b0, "R7");               // R7 single byte
        run_req(2'd2, 1'b1, 16'h0061, 5, 64'h0102030405, 8'h1F, 1'b0, "R8");      // R8 odd rmw, all masked

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R9 watchdog expired act=%0d exp=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule